// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Device Model

This block stands in for a 16-bit asynchronous DRAM with fast page mode on the device side of a controller under test. All strobes are active low and are sampled on a fast system clock. The block finds their edges and works out what each cycle is from the order of those edges. A row address strobe fall while both column strobes are high opens the row on the address pins. A row strobe fall while a column strobe is already low is a CAS-before-RAS refresh. In that case the row comes from an internal counter and the address pins are not used.

While a row is open, every new column strobe fall latches a new column. A write is an early write: if write-enable is low at the column fall, the selected byte lanes are written. Reads drive each byte lane on its own, and only under that lane's column strobe. Where real tri-state pins would sit, the block gives a data output and one output enable per lane.

Storage is a small array, and its row and column depth are parameters. A per-row age counter stands in for cell retention. It raises a sticky error when a row goes too long without a refresh. A second sticky flag reports column strobes that toggle with the row strobe high when no refresh follows them.

Top module: `fpm_dram_model`

## Requirements
- R1: After reset, `dq_oe` is 00, `cyc_kind` is 00, `cbr_row` is 0 and both error flags are 0. One clock edge after `ras_n` is seen high, `dq_oe` is 00 whatever the other strobes do.
- R2: Lane 0 is `dq_out[7:0]` and is strobed by `lcas_n`. Lane 1 is `dq_out[15:8]` and is strobed by `ucas_n`. A lane's `dq_oe` bit is 1 only when all of these hold: a row is open, a column has been latched in this row cycle, that lane's strobe is low, `we_n` is high and `oe_n` is low. The lane then shows the stored byte of the open row and the latched column.
- R3: Take the edge at which the set of low column strobes goes from empty to non-empty while a row is open. If `we_n` is low at that edge, the lanes whose strobe is low take `dq_in`, and the other lane keeps its value. `dq_oe` stays 00 while `we_n` is low.
- R4: A `ras_n` fall with both column strobes high opens the row on `addr` and sets `cyc_kind` to 01. If no column strobe follows, stored data does not change. The fall counts as a refresh of that row.
- R5: A `ras_n` fall with either column strobe low sets `cyc_kind` to 10, refreshes the row given by `cbr_row`, and then advances `cbr_row` by one. The address pins are ignored, and no column strobe activity during that cycle writes or reads data.
- R6: While a row stays open, each new column strobe fall latches the address pins as a fresh column, which gives page mode.
- R7: `cbr_row` is ADDR_W bits wide and wraps from 511 to 0 with the default width.
- R8: A modeled row is selected by the low MEM_ROW_BITS bits of a row address, and a word by those bits joined with the low MEM_COL_BITS bits of the column. `ref_err` goes to 1 and stays there until reset once any modeled row goes more than REF_LIMIT clock cycles without a row-open or CBR refresh of it.
- R9: A column strobe fall with `ras_n` high arms a pending refresh, and the next `ras_n` fall disarms it. A further column strobe fall with `ras_n` high while a refresh is still armed sets `proto_err`, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| ucas_n | input | 1 | Upper-lane column strobe, active low |
| lcas_n | input | 1 | Lower-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | DQ_W | Write data from the controller |
| dq_out | output | DQ_W | Read data toward the controller |
| dq_oe | output | 2 | Per-lane drive enable, bit 1 upper |
| cyc_kind | output | 2 | 00 standby, 01 row open, 10 CBR refresh |
| cbr_row | output | ADDR_W | Internal refresh row counter |
| ref_err | output | 1 | Sticky retention violation |
| proto_err | output | 1 | Sticky strobe order violation |

## Verification
The hardest case to reach is the counter wrap. It needs a full lap of 512 CBR cycles with the strobe order exactly right every time, and any slip there also trips the protocol flag. The bench runs a long burst of CBR cycles and checks that the counter ends one past zero. It also checks the protocol flag at the end of the burst. The retention flag is checked on both sides of its limit, once by idling from reset and once by a refresh sweep over all modeled rows that keeps every row inside the limit.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
   typedef enum logic [1:0] {
      KIND_IDLE = 2'b00,
      KIND_OPEN = 2'b01,
      KIND_CBR  = 2'b10
   } cyc_kind_e;
endpackage

// File: rtl/fpm_strobe_edge.sv
module fpm_strobe_edge #(
   parameter int LANES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ras_n,
   input  logic [LANES-1:0] cas_n,
   output logic             ras_fall,
   output logic             ras_rise,
   output logic             cas_grp_fall,
   output logic             cas_any_low
);
   logic             ras_q;
   logic [LANES-1:0] cas_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q <= 1'b1;
         cas_q <= '1;
      end else begin
         ras_q <= ras_n;
         cas_q <= cas_n;
      end
   end

   assign ras_fall     = ras_q & ~ras_n;
   assign ras_rise     = ~ras_q & ras_n;
   assign cas_any_low  = ~&cas_n;
   assign cas_grp_fall = cas_any_low & (&cas_q);
endmodule

// File: rtl/fpm_cycle_ctl.sv
module fpm_cycle_ctl
   import fpm_pkg::*;
#(
   parameter int ADDR_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ras_fall,
   input  logic              ras_rise,
   input  logic              cas_grp_fall,
   input  logic              cas_any_low,
   output cyc_kind_e         kind,
   output logic [ADDR_W-1:0] row_q,
   output logic [ADDR_W-1:0] col_q,
   output logic              col_vld,
   output logic [ADDR_W-1:0] cbr_cnt,
   output logic              ref_en,
   output logic [ADDR_W-1:0] ref_row,
   output logic              wr_en,
   output logic              proto_err
);
   logic pend;

   assign ref_en  = ras_fall;
   assign ref_row = cas_any_low ? cbr_cnt : addr;
   assign wr_en   = (kind == KIND_OPEN) && !ras_n && cas_grp_fall && !we_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind      <= KIND_IDLE;
         row_q     <= '0;
         col_q     <= '0;
         col_vld   <= 1'b0;
         cbr_cnt   <= '0;
         pend      <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         if (ras_rise) begin
            kind    <= KIND_IDLE;
            col_vld <= 1'b0;
         end else if (ras_fall) begin
            col_vld <= 1'b0;
            pend    <= 1'b0;
            if (cas_any_low) begin
               kind    <= KIND_CBR;
               cbr_cnt <= cbr_cnt + 1'b1;
            end else begin
               kind  <= KIND_OPEN;
               row_q <= addr;
            end
         end else if (kind == KIND_OPEN && cas_grp_fall) begin
            col_q   <= addr;
            col_vld <= 1'b1;
         end
         if (ras_n && cas_grp_fall) begin
            if (pend) proto_err <= 1'b1;
            else      pend      <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/fpm_word_store.sv
module fpm_word_store #(
   parameter int LANES       = 2,
   parameter int LANE_W      = 8,
   parameter int AW          = 6,
   parameter bit RESET_ARRAY = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [LANES-1:0]        wr_mask,
   input  logic [AW-1:0]           wr_addr,
   input  logic [LANES*LANE_W-1:0] wr_data,
   input  logic [AW-1:0]           rd_addr,
   output logic [LANES*LANE_W-1:0] rd_data
);
   localparam int DEPTH = 1 << AW;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] cells [DEPTH];
      if (RESET_ARRAY) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
            end else if (wr_en && wr_mask[l]) begin
               cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (wr_en && wr_mask[l]) cells[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
         end
      end
      assign rd_data[l*LANE_W +: LANE_W] = cells[rd_addr];
   end
endmodule

// File: rtl/fpm_row_age.sv
module fpm_row_age #(
   parameter int ROW_BITS  = 3,
   parameter int REF_LIMIT = 1000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ref_en,
   input  logic [ROW_BITS-1:0] ref_idx,
   output logic                ref_err
);
   localparam int             ROWS  = 1 << ROW_BITS;
   localparam int             AGE_W = $clog2(REF_LIMIT + 2);
   localparam logic [AGE_W-1:0] SAT = AGE_W'(REF_LIMIT + 1);

   logic [ROWS-1:0] over;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [AGE_W-1:0] age;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       age <= '0;
         else if (ref_en && ref_idx == ROW_BITS'(r))       age <= '0;
         else if (age != SAT)                              age <= age + 1'b1;
      end
      assign over[r] = (age == SAT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ref_err <= 1'b0;
      else if (|over) ref_err <= 1'b1;
   end
endmodule

// File: rtl/fpm_dram_model.sv
module fpm_dram_model
   import fpm_pkg::*;
#(
   parameter int ADDR_W       = 9,
   parameter int DQ_W         = 16,
   parameter int MEM_ROW_BITS = 3,
   parameter int MEM_COL_BITS = 3,
   parameter int REF_LIMIT    = 100000,
   parameter bit RESET_ARRAY  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              ucas_n,
   input  logic              lcas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   dq_in,
   output logic [DQ_W-1:0]   dq_out,
   output logic [1:0]        dq_oe,
   output logic [1:0]        cyc_kind,
   output logic [ADDR_W-1:0] cbr_row,
   output logic              ref_err,
   output logic              proto_err
);
   localparam int LANES  = 2;
   localparam int LANE_W = DQ_W / LANES;
   localparam int AW     = MEM_ROW_BITS + MEM_COL_BITS;

   if (DQ_W % LANES != 0) begin : g_bad_dq
      $error("DQ_W must split into two equal lanes");
   end
   if (MEM_ROW_BITS < 1 || MEM_ROW_BITS > ADDR_W || MEM_COL_BITS < 1 || MEM_COL_BITS > ADDR_W) begin : g_bad_mem
      $error("modeled array bits must lie within the address width");
   end
   if (REF_LIMIT < 1) begin : g_bad_lim
      $error("REF_LIMIT must be positive");
   end

   logic [LANES-1:0]  cas_n;
   logic              ras_fall, ras_rise, cas_grp_fall, cas_any_low;
   cyc_kind_e         kind;
   logic [ADDR_W-1:0] row_q, col_q, ref_row;
   logic              col_vld, ref_en, wr_en;
   logic              unused_hi_bits;

   assign cas_n          = {ucas_n, lcas_n};
   assign unused_hi_bits = ^{row_q, col_q, ref_row};

   fpm_strobe_edge #(.LANES(LANES)) u_edge (
      .clk, .rst_n, .ras_n, .cas_n,
      .ras_fall, .ras_rise, .cas_grp_fall, .cas_any_low
   );

   fpm_cycle_ctl #(.ADDR_W(ADDR_W)) u_ctl (
      .clk, .rst_n, .ras_n, .we_n, .addr,
      .ras_fall, .ras_rise, .cas_grp_fall, .cas_any_low,
      .kind, .row_q, .col_q, .col_vld, .cbr_cnt(cbr_row),
      .ref_en, .ref_row, .wr_en, .proto_err
   );

   fpm_word_store #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW), .RESET_ARRAY(RESET_ARRAY)) u_store (
      .clk, .rst_n, .wr_en,
      .wr_mask(~cas_n),
      .wr_addr({row_q[MEM_ROW_BITS-1:0], addr[MEM_COL_BITS-1:0]}),
      .wr_data(dq_in),
      .rd_addr({row_q[MEM_ROW_BITS-1:0], col_q[MEM_COL_BITS-1:0]}),
      .rd_data(dq_out)
   );

   fpm_row_age #(.ROW_BITS(MEM_ROW_BITS), .REF_LIMIT(REF_LIMIT)) u_age (
      .clk, .rst_n, .ref_en,
      .ref_idx(ref_row[MEM_ROW_BITS-1:0]),
      .ref_err
   );

   for (genvar l = 0; l < LANES; l++) begin : g_oe
      assign dq_oe[l] = (kind == KIND_OPEN) && col_vld && !cas_n[l] && we_n && !oe_n;
   end

   assign cyc_kind = kind;
endmodule

// File: rtl/fpm_dram_checker.sv
module fpm_dram_checker #(
   parameter int ADDR_W = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ras_n,
   input logic              ucas_n,
   input logic              lcas_n,
   input logic              we_n,
   input logic              oe_n,
   input logic [1:0]        dq_oe,
   input logic [1:0]        cyc_kind,
   input logic [ADDR_W-1:0] cbr_row,
   input logic              ref_err,
   input logic              proto_err
);
   AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
      (ras_n && $past(ras_n)) |-> (dq_oe == 2'b00)); // R1

   AST_UPPER_LANE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe[1] |-> (!ucas_n && !oe_n)); // R2

   AST_LOWER_LANE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe[0] |-> (!lcas_n && !oe_n)); // R2

   AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (dq_oe == 2'b00)); // R3

   AST_CBR_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ras_n) && !ras_n && !(ucas_n && lcas_n)) |=> (cyc_kind == 2'b10)); // R5

   AST_CBR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cbr_row != $past(cbr_row)) |-> (cbr_row == ADDR_W'($past(cbr_row) + 1'b1))); // R7

   AST_REF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ref_err) |-> ref_err); // R8

   AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(proto_err) |-> proto_err); // R9
endmodule

bind fpm_dram_model fpm_dram_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n),
   .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe), .cyc_kind(cyc_kind),
   .cbr_row(cbr_row), .ref_err(ref_err), .proto_err(proto_err)
);

// File: tb/test_fpm_dram_model.sv
`timescale 1ns/1ps
module test_fpm_dram_model;
   localparam int ADDR_W = 9;
   localparam int DQ_W   = 16;
   localparam int LIMIT  = 400;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ras_n = 1'b1, ucas_n = 1'b1, lcas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [DQ_W-1:0]   dq_in = '0;
   logic [DQ_W-1:0]   dq_out;
   logic [1:0]        dq_oe, cyc_kind;
   logic [ADDR_W-1:0] cbr_row;
   logic              ref_err, proto_err;

   int          n_vec = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;
   logic [15:0] model [64];
   logic [2:0]  cur_row = '0;

   fpm_dram_model #(.REF_LIMIT(LIMIT)) i_fpm_dram_model (
      .clk, .rst_n, .ras_n, .ucas_n, .lcas_n, .we_n, .oe_n, .addr, .dq_in,
      .dq_out, .dq_oe, .cyc_kind, .cbr_row, .ref_err, .proto_err
   );

   always #2 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] pat(input int r, input int c, input int salt);
      return 16'(r * 4099 + c * 263 + salt * 917 + 16'h5a3c);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0; ras_n = 1'b1; ucas_n = 1'b1; lcas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic open_row(input logic [ADDR_W-1:0] r);
      addr = r; ras_n = 1'b0; cur_row = r[2:0];
      @(negedge clk);
   endtask

   task automatic close_row();
      ras_n = 1'b1; ucas_n = 1'b1; lcas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr(input logic [ADDR_W-1:0] c, input logic [1:0] m, input logic [15:0] d);
      addr = c; dq_in = d; we_n = 1'b0; oe_n = 1'b0; lcas_n = !m[0]; ucas_n = !m[1];
      @(negedge clk);
      chk("R3 write leaves lanes undriven", dq_oe, 2'b00);
      if (m[0]) model[{cur_row, c[2:0]}][7:0]  = d[7:0];
      if (m[1]) model[{cur_row, c[2:0]}][15:8] = d[15:8];
      ucas_n = 1'b1; lcas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic rd(input logic [ADDR_W-1:0] c, input logic [1:0] m, input string tag);
      logic [15:0] lm;
      lm = {{8{m[1]}}, {8{m[0]}}};
      addr = c; we_n = 1'b1; oe_n = 1'b0; lcas_n = !m[0]; ucas_n = !m[1];
      @(negedge clk);
      chk({tag, " lane enables"}, dq_oe, m);
      chk({tag, " read data"}, dq_out & lm, model[{cur_row, c[2:0]}] & lm);
      ucas_n = 1'b1; lcas_n = 1'b1; oe_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cbr(input logic [ADDR_W-1:0] junk, input bit probe);
      lcas_n = 1'b0; addr = junk;
      @(negedge clk);
      ras_n = 1'b0;
      @(negedge clk);
      if (probe) chk("R5 CBR kind", cyc_kind, 2'b10);
      lcas_n = 1'b1;
      @(negedge clk);
      if (probe) begin
         we_n = 1'b0; oe_n = 1'b0; dq_in = 16'hdead; ucas_n = 1'b0; lcas_n = 1'b0;
         @(negedge clk);
         chk("R5 no data during CBR", dq_oe, 2'b00);
         ucas_n = 1'b1; lcas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
         @(negedge clk);
      end
      ras_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic read_all(input string tag);
      for (int r = 0; r < 8; r++) begin
         open_row(ADDR_W'(r * 73));
         for (int c = 0; c < 8; c++) rd(ADDR_W'(c * 9 + 200), 2'b11, tag);
         close_row();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 64; i++) model[i] = '0;
      do_reset();
      chk("R1 reset dq_oe", dq_oe, 2'b00);
      chk("R1 reset kind", cyc_kind, 2'b00);
      chk("R1 reset cbr_row", cbr_row, 0);
      chk("R1 reset ref_err", ref_err, 0);
      chk("R1 reset proto_err", proto_err, 0);

      // R8: age limit crossed by idling from reset
      repeat (388) @(negedge clk);
      chk("R8 no error inside limit", ref_err, 0);
      repeat (20) @(negedge clk);
      chk("R8 error past limit", ref_err, 1);

      // R1 and R9: strobes with row strobe high
      do_reset();
      we_n = 1'b1; oe_n = 1'b0; ucas_n = 1'b0; lcas_n = 1'b0;
      @(negedge clk);
      chk("R1 standby high-Z", dq_oe, 2'b00);
      chk("R9 first fall legal", proto_err, 0);
      ucas_n = 1'b1; lcas_n = 1'b1;
      @(negedge clk);
      lcas_n = 1'b0;
      @(negedge clk);
      chk("R9 second fall flagged", proto_err, 1);
      do_reset();
      chk("R9 cleared by reset", proto_err, 0);

      // R6: page-mode fill of every modeled word, then read back
      for (int r = 0; r < 8; r++) begin
         open_row(ADDR_W'(r * 73));
         chk("R4 row open kind", cyc_kind, 2'b01);
         for (int c = 0; c < 8; c++) wr(ADDR_W'(c * 9 + 64), 2'b11, pat(r, c, 0));
         close_row();
      end
      read_all("R6 page read");

      // R3: byte writes
      open_row(ADDR_W'(2));
      wr(ADDR_W'(3), 2'b01, pat(2, 3, 5));
      wr(ADDR_W'(4), 2'b10, pat(2, 4, 6));
      rd(ADDR_W'(3), 2'b11, "R3 lower-only write");
      rd(ADDR_W'(4), 2'b11, "R3 upper-only write");
      // R2: byte reads
      rd(ADDR_W'(3), 2'b10, "R2 upper-lane read");
      rd(ADDR_W'(4), 2'b01, "R2 lower-lane read");
      close_row();
      chk("R1 idle after close", cyc_kind, 2'b00);

      // R4: row-only refresh
      open_row(ADDR_W'(5));
      chk("R4 refresh row open", cyc_kind, 2'b01);
      chk("R4 refresh no drive", dq_oe, 2'b00);
      close_row();

      // R5: CBR with junk address and attempted write
      cbr(ADDR_W'(9'h1ff), 1'b1);
      chk("R5 counter advanced", cbr_row, 1);
      read_all("R5 array unchanged");
      chk("R9 CBR sequence legal", proto_err, 0);

      // R7: full lap of the refresh counter
      do_reset();
      for (int i = 0; i < 513; i++) cbr(ADDR_W'(i), 1'b0);
      chk("R7 counter wraps", cbr_row, 1);
      chk("R9 long CBR burst legal", proto_err, 0);

      // R8: periodic refresh keeps the flag low
      do_reset();
      for (int p = 0; p < 4; p++) begin
         if (p[0]) begin
            for (int r = 0; r < 8; r++) begin open_row(ADDR_W'(r + 8 * p)); close_row(); end
         end else begin
            for (int r = 0; r < 8; r++) cbr(ADDR_W'(r), 1'b0);
         end
         repeat (200) @(negedge clk);
      end
      chk("R8 refreshed rows stay clean", ref_err, 0);
      repeat (420) @(negedge clk);
      chk("R8 stale rows flagged", ref_err, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule